// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the register face of an SMBus host controller. Software sees a small byte-addressed register file: a status register with sticky flags, a control register carrying the transaction type, start, kill and PEC-enable bits, a command byte, a slave address byte, two data bytes and an auxiliary control byte. Writing the control register with the start bit set launches one bus transaction. The block then steps a byte-level bus engine through the phases that transaction needs: start condition, address byte, command byte, repeated start, data bytes and stop condition.

Quick, byte, byte-data and word-data transactions are carried out, in both directions. The result of a transaction is reported through sticky status flags, which software clears by writing ones. Bit-level clock and data timing is not part of this block. A behavioural byte engine stands in for the wire. Each engine operation takes a fixed number of cycles and reports the slave's acknowledge, any arbitration loss and the byte that was read. The current bus phase and the byte being sent are exported so the phase ordering can be observed.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every register reads 0, including status, control, command, address, data0, data1 and auxiliary control, and `bus_phase` is 0 (idle).
- R2: The command register is at offset 3, the address register at 4 (slave address in bits [7:1], read/write in bit 0 where 1 means read), data0 at 5 and data1 at 6. Each of these reads back what was written. Auxiliary control at offset 13 keeps bits [1:0] only. Offsets 7, 8, 12 and any unmapped offset read 0. Every read returns data one cycle after the address is presented.
- R3: The control register is at offset 2. Transaction type is in bits [4:2], PEC enable in bit 7, kill in bit 1 and start in bit 6. A read returns type, PEC and kill as stored, and bits 6, 5 and 0 always read 0.
- R4: A start accepted while idle sets status bit 0 (busy). Busy stays set for the whole transaction. Busy clears on the same edge that the outcome flag is set.
- R5: Type 0 (quick) runs the phases start, address, stop. A transaction that ends without error sets status bit 1 (complete). Phase codes on `bus_phase` are: 1 start, 2 address, 3 command, 4 repeated start, 5 first data byte, 6 second data byte, 7 stop, 0 idle.
- R6: Type 1 (byte) sends the command register as its one byte when writing. When reading, it returns one byte from the slave into data0.
- R7: Type 2 (byte-data) and type 3 (word-data) send address and command. A write then sends data0 (and data1 for word). A read issues a repeated start, a second address byte with bit 0 set (the first address byte always has bit 0 clear), and reads into data0 and, for word, data1 (low byte first).
- R8: A missing acknowledge on an address, command or written data byte moves directly to a stop, then sets status bit 2 (device error) and not bit 1.
- R9: Arbitration loss during an engine operation ends the transaction at once without a stop. It sets status bit 3 (bus error) and not bit 1.
- R10: Control bit 1 (kill) set during a transaction ends it on the next edge, clears busy and sets status bit 4 (failed). Kill set while idle changes no status.
- R11: While busy, a control write changes only the kill bit. A start is ignored. Writes to command, address, data and auxiliary control are ignored. The running transaction completes unchanged.
- R12: Writing status with a 1 in any of bits [4:1] clears that flag. Bits written 0 leave their flags as they are. If a set and a clear fall on the same edge, the set wins.
- R13: A start with an unsupported type code (4 to 7, block and I2C-block included) causes no bus activity and sets status bit 4 (failed) on the write edge. Busy never sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| slv_ack | input | 1 | Slave acknowledges bytes sent to it |
| slv_rdata | input | 16 | Bytes the slave returns (low byte first) |
| arb_lost | input | 1 | Arbitration loss seen by the bus engine |
| bus_phase | output | 3 | Current bus phase code |
| bus_byte | output | 8 | Byte driven in the current phase, 0 if none |

## Verification
A register read returns its value on the clock after the address is presented. A start becomes visible as busy on the first read after the write. With the default engine latency of 4, each bus phase lasts BYTE_CYCLES+2 = 6 cycles, so a word read takes about 48 cycles. The bench therefore polls the busy bit rather than counting cycles, and reads the flags and data only after busy is seen low. The outcome flag and the busy drop share one edge, so the first idle read already carries the final status. Kill takes effect on the edge after the kill write, so the bench waits one extra cycle before reading. An unsupported type sets the failed flag on the write edge itself, so the very next read must show it.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  localparam int SMB_DW = 8;

  // register offsets
  localparam int OFS_STAT = 0;
  localparam int OFS_CTRL = 2;
  localparam int OFS_CMD  = 3;
  localparam int OFS_ADR  = 4;
  localparam int OFS_D0   = 5;
  localparam int OFS_D1   = 6;
  localparam int OFS_AUX  = 13;

  // control bit positions
  localparam int CB_KILL  = 1;
  localparam int CB_TLO   = 2;
  localparam int CB_THI   = 4;
  localparam int CB_START = 6;
  localparam int CB_PEC   = 7;

  // status bit positions
  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 1;
  localparam int SB_DEV  = 2;
  localparam int SB_BUS  = 3;
  localparam int SB_FAIL = 4;

  // transaction type codes
  localparam logic [2:0] XT_QUICK = 3'd0;
  localparam logic [2:0] XT_BYTE  = 3'd1;
  localparam logic [2:0] XT_BDATA = 3'd2;
  localparam logic [2:0] XT_WORD  = 3'd3;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_ADDR   = 3'd2,
    PH_CMD    = 3'd3,
    PH_RSTART = 3'd4,
    PH_DATA0  = 3'd5,
    PH_DATA1  = 3'd6,
    PH_STOP   = 3'd7
  } phase_e;

endpackage

// File: rtl/smbh_byte_eng.sv
module smbh_byte_eng #(
  parameter int BYTE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort_i,
  input  logic       req_i,
  input  logic       arb_lost_i,
  input  logic       slv_ack_i,
  input  logic [7:0] rbyte_i,
  output logic       done_o,
  output logic       ack_o,
  output logic       lost_o,
  output logic [7:0] rbyte_o
);
  localparam int CW = $clog2(BYTE_CYCLES + 1);

  logic          active_q;
  logic          lost_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      active_q <= 1'b0;
      lost_q   <= 1'b0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
      ack_o    <= 1'b0;
      lost_o   <= 1'b0;
      rbyte_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (req_i) begin
        active_q <= 1'b1;
        lost_q   <= 1'b0;
        cnt_q    <= CW'(BYTE_CYCLES - 1);
      end else if (active_q) begin
        if (arb_lost_i) lost_q <= 1'b1;
        if (cnt_q == '0) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
          ack_o    <= slv_ack_i;
          lost_o   <= lost_q | arb_lost_i;
          rbyte_o  <= rbyte_i;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  // a result is only ever reported at the end of an operation in progress
  a_r4_done_after_active: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(active_q));
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [2:0] xtype_i,
  input  logic       rw_i,
  input  logic [6:0] sadr_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] d0_i,
  input  logic [7:0] d1_i,
  input  logic       kill_i,
  input  logic       eng_done_i,
  input  logic       eng_ack_i,
  input  logic       eng_lost_i,
  input  logic [7:0] eng_rbyte_i,
  output phase_e     phase_o,
  output logic [7:0] byte_o,
  output logic       op_req_o,
  output logic       abort_o,
  output logic       fin_ok_o,
  output logic       fin_dev_o,
  output logic       fin_bus_o,
  output logic       fin_fail_o,
  output logic       cap0_o,
  output logic       cap1_o,
  output logic [7:0] cap_byte_o
);
  phase_e     state_q, state_d;
  logic [7:0] byte_q, byte_d;
  logic       dev_q, dev_d;
  logic       sec_q, sec_d;
  logic [2:0] type_q;
  logic       op_req_q;
  logic       combined;

  assign combined = (type_q == XT_BDATA) || (type_q == XT_WORD);

  always_comb begin
    state_d    = state_q;
    byte_d     = byte_q;
    dev_d      = dev_q;
    sec_d      = sec_q;
    fin_ok_o   = 1'b0;
    fin_dev_o  = 1'b0;
    fin_bus_o  = 1'b0;
    fin_fail_o = 1'b0;
    cap0_o     = 1'b0;
    cap1_o     = 1'b0;
    abort_o    = 1'b0;
    if (state_q == PH_IDLE) begin
      if (start_i) begin
        if (xtype_i <= XT_WORD) begin
          state_d = PH_START;
          dev_d   = 1'b0;
          sec_d   = 1'b0;
          byte_d  = '0;
        end else begin
          fin_fail_o = 1'b1;
        end
      end
    end else if (kill_i) begin
      state_d    = PH_IDLE;
      byte_d     = '0;
      abort_o    = 1'b1;
      fin_fail_o = 1'b1;
    end else if (eng_done_i) begin
      if (eng_lost_i) begin
        state_d   = PH_IDLE;
        byte_d    = '0;
        fin_bus_o = 1'b1;
      end else begin
        unique case (state_q)
          PH_START: begin
            state_d = PH_ADDR;
            byte_d  = {sadr_i, combined ? 1'b0 : rw_i};
          end
          PH_ADDR: begin
            if (!eng_ack_i) begin
              state_d = PH_STOP; byte_d = '0; dev_d = 1'b1;
            end else if (sec_q) begin
              state_d = PH_DATA0; byte_d = '0;
            end else if (type_q == XT_QUICK) begin
              state_d = PH_STOP; byte_d = '0;
            end else if (type_q == XT_BYTE && rw_i) begin
              state_d = PH_DATA0; byte_d = '0;
            end else begin
              state_d = PH_CMD; byte_d = cmd_i;
            end
          end
          PH_CMD: begin
            if (!eng_ack_i) begin
              state_d = PH_STOP; byte_d = '0; dev_d = 1'b1;
            end else if (type_q == XT_BYTE) begin
              state_d = PH_STOP; byte_d = '0;
            end else if (rw_i) begin
              state_d = PH_RSTART; byte_d = '0;
            end else begin
              state_d = PH_DATA0; byte_d = d0_i;
            end
          end
          PH_RSTART: begin
            state_d = PH_ADDR;
            sec_d   = 1'b1;
            byte_d  = {sadr_i, 1'b1};
          end
          PH_DATA0: begin
            if (!rw_i && !eng_ack_i) begin
              state_d = PH_STOP; byte_d = '0; dev_d = 1'b1;
            end else begin
              cap0_o = rw_i;
              if (type_q == XT_WORD) begin
                state_d = PH_DATA1; byte_d = rw_i ? 8'h00 : d1_i;
              end else begin
                state_d = PH_STOP; byte_d = '0;
              end
            end
          end
          PH_DATA1: begin
            if (!rw_i && !eng_ack_i) begin
              dev_d = 1'b1;
            end else begin
              cap1_o = rw_i;
            end
            state_d = PH_STOP;
            byte_d  = '0;
          end
          PH_STOP: begin
            state_d   = PH_IDLE;
            byte_d    = '0;
            fin_ok_o  = !dev_q;
            fin_dev_o = dev_q;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PH_IDLE;
      byte_q   <= '0;
      dev_q    <= 1'b0;
      sec_q    <= 1'b0;
      type_q   <= XT_QUICK;
      op_req_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      byte_q   <= byte_d;
      dev_q    <= dev_d;
      sec_q    <= sec_d;
      op_req_q <= (state_d != PH_IDLE) && (state_d != state_q);
      if (state_q == PH_IDLE && start_i) type_q <= xtype_i;
    end
  end

  assign phase_o    = state_q;
  assign byte_o     = byte_q;
  assign op_req_o   = op_req_q;
  assign cap_byte_o = eng_rbyte_i;

  // a phase holds until the engine reports back or kill arrives
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q != PH_IDLE) && !kill_i && !eng_done_i |=> state_q == $past(state_q));
  // kill returns the sequencer to idle on the next edge
  a_r10_kill_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q != PH_IDLE) && kill_i |=> state_q == PH_IDLE);
  // arbitration loss leaves without a stop phase
  a_r9_lost_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q != PH_IDLE) && !kill_i && eng_done_i && eng_lost_i |=> state_q == PH_IDLE);
  // at most one outcome per transaction end
  a_r13_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fin_ok_o, fin_dev_o, fin_bus_o, fin_fail_o}));

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbh_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int BYTE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              slv_ack,
  input  logic [15:0]       slv_rdata,
  input  logic              arb_lost,
  output logic [2:0]        bus_phase,
  output logic [7:0]        bus_byte
);
  localparam int DW = SMB_DW;

  phase_e        phase;
  logic          busy;
  logic [2:0]    xtype_q;
  logic          pec_q, kill_q;
  logic [DW-1:0] cmd_q, adr_q, d0_q, d1_q;
  logic [1:0]    aux_q;
  logic          st_done, st_dev, st_bus, st_fail;

  logic wr_stat, wr_ctrl, wr_cmd, wr_adr, wr_d0, wr_d1, wr_aux, start_go;

  logic          eng_req, eng_abort, eng_done, eng_ack, eng_lost;
  logic [DW-1:0] eng_rbyte, rd_pick;
  logic          fin_ok, fin_dev, fin_bus, fin_fail, cap0, cap1;
  logic [DW-1:0] cap_byte, seq_byte;

  assign busy     = (phase != PH_IDLE);
  assign wr_stat  = reg_we && (reg_addr == ADDR_W'(OFS_STAT));
  assign wr_ctrl  = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_cmd   = reg_we && (reg_addr == ADDR_W'(OFS_CMD)) && !busy;
  assign wr_adr   = reg_we && (reg_addr == ADDR_W'(OFS_ADR)) && !busy;
  assign wr_d0    = reg_we && (reg_addr == ADDR_W'(OFS_D0))  && !busy;
  assign wr_d1    = reg_we && (reg_addr == ADDR_W'(OFS_D1))  && !busy;
  assign wr_aux   = reg_we && (reg_addr == ADDR_W'(OFS_AUX)) && !busy;
  assign start_go = wr_ctrl && reg_wdata[CB_START] && !busy;
  assign rd_pick  = (phase == PH_DATA1) ? slv_rdata[15:8] : slv_rdata[7:0];

  smbh_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_go),
    .xtype_i    (reg_wdata[CB_THI:CB_TLO]),
    .rw_i       (adr_q[0]),
    .sadr_i     (adr_q[7:1]),
    .cmd_i      (cmd_q),
    .d0_i       (d0_q),
    .d1_i       (d1_q),
    .kill_i     (kill_q),
    .eng_done_i (eng_done),
    .eng_ack_i  (eng_ack),
    .eng_lost_i (eng_lost),
    .eng_rbyte_i(eng_rbyte),
    .phase_o    (phase),
    .byte_o     (seq_byte),
    .op_req_o   (eng_req),
    .abort_o    (eng_abort),
    .fin_ok_o   (fin_ok),
    .fin_dev_o  (fin_dev),
    .fin_bus_o  (fin_bus),
    .fin_fail_o (fin_fail),
    .cap0_o     (cap0),
    .cap1_o     (cap1),
    .cap_byte_o (cap_byte)
  );

  smbh_byte_eng #(.BYTE_CYCLES(BYTE_CYCLES)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .abort_i   (eng_abort),
    .req_i     (eng_req),
    .arb_lost_i(arb_lost),
    .slv_ack_i (slv_ack),
    .rbyte_i   (rd_pick),
    .done_o    (eng_done),
    .ack_o     (eng_ack),
    .lost_o    (eng_lost),
    .rbyte_o   (eng_rbyte)
  );

  // configuration and data registers
  always_ff @(posedge clk) begin
    if (rst) begin
      xtype_q <= '0;
      pec_q   <= 1'b0;
      kill_q  <= 1'b0;
      cmd_q   <= '0;
      adr_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      aux_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        kill_q <= reg_wdata[CB_KILL];
        if (!busy) begin
          xtype_q <= reg_wdata[CB_THI:CB_TLO];
          pec_q   <= reg_wdata[CB_PEC];
        end
      end
      if (wr_cmd) cmd_q <= reg_wdata;
      if (wr_adr) adr_q <= reg_wdata;
      if (wr_aux) aux_q <= reg_wdata[1:0];
      if (cap0)       d0_q <= cap_byte;
      else if (wr_d0) d0_q <= reg_wdata;
      if (cap1)       d1_q <= cap_byte;
      else if (wr_d1) d1_q <= reg_wdata;
    end
  end

  // sticky status, write one to clear, set wins
  always_ff @(posedge clk) begin
    if (rst) begin
      st_done <= 1'b0;
      st_dev  <= 1'b0;
      st_bus  <= 1'b0;
      st_fail <= 1'b0;
    end else begin
      if (wr_stat) begin
        if (reg_wdata[SB_DONE]) st_done <= 1'b0;
        if (reg_wdata[SB_DEV])  st_dev  <= 1'b0;
        if (reg_wdata[SB_BUS])  st_bus  <= 1'b0;
        if (reg_wdata[SB_FAIL]) st_fail <= 1'b0;
      end
      if (fin_ok)   st_done <= 1'b1;
      if (fin_dev)  st_dev  <= 1'b1;
      if (fin_bus)  st_bus  <= 1'b1;
      if (fin_fail) st_fail <= 1'b1;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_W'(OFS_STAT): reg_rdata <= {3'b000, st_fail, st_bus, st_dev, st_done, busy};
        ADDR_W'(OFS_CTRL): reg_rdata <= {pec_q, 2'b00, xtype_q, kill_q, 1'b0};
        ADDR_W'(OFS_CMD):  reg_rdata <= cmd_q;
        ADDR_W'(OFS_ADR):  reg_rdata <= adr_q;
        ADDR_W'(OFS_D0):   reg_rdata <= d0_q;
        ADDR_W'(OFS_D1):   reg_rdata <= d1_q;
        ADDR_W'(OFS_AUX):  reg_rdata <= {6'b000000, aux_q};
        default:           reg_rdata <= '0;
      endcase
    end
  end

  assign bus_phase = phase;
  assign bus_byte  = seq_byte;

  // control fields stay frozen while a transaction runs
  a_r11_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    busy && wr_ctrl |=> $stable(xtype_q) && $stable(pec_q));
  // kill ends a running transaction as failed
  a_r10_kill_fails: assert property (@(posedge clk) disable iff (rst)
    busy && kill_q |=> !busy && st_fail);
  // a missing acknowledge never reports completion
  a_r8_nack_no_done: assert property (@(posedge clk) disable iff (rst)
    $rose(st_dev) |-> !$rose(st_done));
  // busy only drops together with an outcome
  a_r4_busy_outcome: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (st_done || st_dev || st_bus || st_fail));

endmodule

// File: tb/smbus_host_regs_tb_top.sv
module smbus_host_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        slv_ack = 1'b1;
  logic [15:0] slv_rdata = '0;
  logic        arb_lost = 1'b0;
  logic [2:0]  bus_phase;
  logic [7:0]  bus_byte;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_host_regs dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slv_ack(slv_ack),
    .slv_rdata(slv_rdata), .arb_lost(arb_lost), .bus_phase(bus_phase),
    .bus_byte(bus_byte)
  );

  // phase and address-byte logs
  logic [31:0] plog;
  logic [15:0] alog;
  int          pn, an;
  logic [2:0]  prev_ph = 3'd0;

  always @(negedge clk) begin
    if (bus_phase != prev_ph && bus_phase != 3'd0) begin
      plog = plog | (32'(bus_phase) << (4 * pn));
      pn = pn + 1;
      if (bus_phase == 3'd2) begin
        alog = alog | (16'(bus_byte) << (8 * an));
        an = an + 1;
      end
    end
    prev_ph = bus_phase;
  end

  task automatic clr_log();
    #1;
    plog = '0; alog = '0; pn = 0; an = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] v;
    int k;
    k = 0;
    rd(4'd0, v);
    while (v[0] && k < 400) begin
      rd(4'd0, v);
      k++;
    end
    if (v[0]) chk(tag, 32'(v[0]), 32'd0);
  endtask

  typedef struct packed {
    logic [2:0]  xt;
    logic        rw;
    logic [6:0]  sa;
    logic [7:0]  cmd;
    logic [7:0]  d0;
    logic [7:0]  d1;
    logic [15:0] srd;
    logic [31:0] plog;
    logic [15:0] alog;
    logic [7:0]  ed0;
    logic [7:0]  ed1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 7'h50, 8'h00, 8'h11, 8'h22, 16'h0000, 32'h00000721, 16'h00A0, 8'h11, 8'h22},
    '{3'd0, 1'b1, 7'h3A, 8'h00, 8'h11, 8'h22, 16'h0000, 32'h00000721, 16'h0075, 8'h11, 8'h22},
    '{3'd1, 1'b0, 7'h10, 8'h9C, 8'h33, 8'h44, 16'h0000, 32'h00007321, 16'h0020, 8'h33, 8'h44},
    '{3'd1, 1'b1, 7'h10, 8'h00, 8'h33, 8'h44, 16'h00A5, 32'h00007521, 16'h0021, 8'hA5, 8'h44},
    '{3'd2, 1'b0, 7'h2C, 8'h05, 8'h6B, 8'h22, 16'h0000, 32'h00075321, 16'h0058, 8'h6B, 8'h22},
    '{3'd2, 1'b1, 7'h2C, 8'h06, 8'h00, 8'h22, 16'h7E81, 32'h07524321, 16'h5958, 8'h81, 8'h22},
    '{3'd3, 1'b0, 7'h48, 8'h07, 8'h12, 8'h34, 16'h0000, 32'h00765321, 16'h0090, 8'h12, 8'h34},
    '{3'd3, 1'b1, 7'h48, 8'h08, 8'h00, 8'h00, 16'hBEEF, 32'h76524321, 16'h9190, 8'hEF, 8'hBE}
  };

  function automatic string tag_of(input logic [2:0] xt);
    if (xt == 3'd0) return "R5 quick";
    if (xt == 3'd1) return "R6 byte";
    return "R7 data/word";
  endfunction

  initial begin
    repeat (3000) @(posedge clk);
    #1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    vec_t       t;
    string      tg;
    clr_log();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'd0, v);  chk("R1 status", 32'(v), 32'h00);
    rd(4'd2, v);  chk("R1 control", 32'(v), 32'h00);
    rd(4'd5, v);  chk("R1 data0", 32'(v), 32'h00);
    rd(4'd13, v); chk("R1 aux", 32'(v), 32'h00);
    chk("R1 phase", 32'(bus_phase), 32'd0);

    // R2 register map
    wr(4'd3, 8'h5A);  rd(4'd3, v);  chk("R2 command", 32'(v), 32'h5A);
    wr(4'd4, 8'hA7);  rd(4'd4, v);  chk("R2 address", 32'(v), 32'hA7);
    wr(4'd6, 8'hC3);  rd(4'd6, v);  chk("R2 data1", 32'(v), 32'hC3);
    wr(4'd13, 8'hFF); rd(4'd13, v); chk("R2 aux", 32'(v), 32'h03);
    wr(4'd9, 8'hFF);  rd(4'd9, v);  chk("R2 unmapped", 32'(v), 32'h00);
    rd(4'd7, v);      chk("R2 block data reads 0", 32'(v), 32'h00);
    wr(4'd13, 8'h00);

    // R3 control readback, R10 kill while idle
    wr(4'd2, 8'hBD); rd(4'd2, v); chk("R3 control fields", 32'(v), 32'h9C);
    wr(4'd2, 8'h02); rd(4'd2, v); chk("R3 kill readback", 32'(v), 32'h02);
    rd(4'd0, v); chk("R10 idle kill no status", 32'(v), 32'h00);
    wr(4'd2, 8'h00);

    // vector table: all supported types and directions
    for (int i = 0; i < NV; i++) begin
      t  = VEC[i];
      tg = tag_of(t.xt);
      slv_ack   = 1'b1;
      slv_rdata = t.srd;
      wr(4'd4, {t.sa, t.rw});
      wr(4'd3, t.cmd);
      wr(4'd5, t.d0);
      wr(4'd6, t.d1);
      clr_log();
      wr(4'd2, 8'h40 | {3'b000, t.xt, 2'b00});
      rd(4'd0, v); chk("R4 busy after start", 32'(v[0]), 32'd1);
      wait_idle("R4 busy timeout");
      rd(4'd0, v); chk({tg, " status"}, 32'(v), 32'h02);
      chk({tg, " phases"}, plog, t.plog);
      chk({tg, " address bytes"}, 32'(alog), 32'(t.alog));
      rd(4'd5, v); chk({tg, " data0"}, 32'(v), 32'(t.ed0));
      rd(4'd6, v); chk({tg, " data1"}, 32'(v), 32'(t.ed1));
      rd(4'd2, v); chk("R3 start reads 0", 32'(v), 32'({3'b000, t.xt, 2'b00}));
      if (i == 0) begin
        // R12 write-zero keeps, write-one clears
        wr(4'd0, 8'h1C); rd(4'd0, v); chk("R12 other bits keep flag", 32'(v), 32'h02);
      end
      wr(4'd0, 8'h02); rd(4'd0, v); chk("R12 clear complete", 32'(v), 32'h00);
    end

    // R8 missing acknowledge on address
    slv_ack = 1'b0;
    wr(4'd4, 8'h58); wr(4'd3, 8'h01);
    clr_log();
    wr(4'd2, 8'h48);
    wait_idle("R8 busy timeout");
    rd(4'd0, v); chk("R8 device error only", 32'(v), 32'h04);
    chk("R8 phases end with stop", plog, 32'h00000721);
    wr(4'd0, 8'h1E); rd(4'd0, v); chk("R12 clear device error", 32'(v), 32'h00);
    slv_ack = 1'b1;

    // R9 arbitration loss during address phase
    wr(4'd4, 8'h20); wr(4'd3, 8'h77);
    clr_log();
    wr(4'd2, 8'h44);
    begin
      int k;
      k = 0;
      while (bus_phase != 3'd2 && k < 100) begin @(negedge clk); k++; end
    end
    arb_lost = 1'b1;
    @(negedge clk); @(negedge clk);
    arb_lost = 1'b0;
    wait_idle("R9 busy timeout");
    rd(4'd0, v); chk("R9 bus error only", 32'(v), 32'h08);
    chk("R9 no stop phase", plog, 32'h00000021);
    wr(4'd0, 8'h1E);

    // R10 kill during a word read
    slv_rdata = 16'h1234;
    wr(4'd4, 8'h91);
    clr_log();
    wr(4'd2, 8'h4C);
    repeat (10) @(negedge clk);
    wr(4'd2, 8'h0E);
    @(negedge clk);
    rd(4'd0, v); chk("R10 kill status", 32'(v), 32'h10);
    chk("R10 kill phase idle", 32'(bus_phase), 32'd0);
    rd(4'd2, v); chk("R10 kill readback", 32'(v), 32'h0E);
    wr(4'd2, 8'h00);
    wr(4'd0, 8'h1E);

    // R11 writes while busy ignored
    slv_rdata = 16'hBEEF;
    wr(4'd4, 8'h91);
    clr_log();
    wr(4'd2, 8'h4C);
    wr(4'd2, 8'h44);
    wr(4'd4, 8'h00);
    rd(4'd2, v); chk("R11 control kept while busy", 32'(v), 32'h0C);
    wait_idle("R11 busy timeout");
    rd(4'd0, v); chk("R11 completes", 32'(v), 32'h02);
    chk("R11 phases unchanged", plog, 32'h76524321);
    rd(4'd4, v); chk("R11 address kept", 32'(v), 32'h91);
    wr(4'd0, 8'h02);

    // R13 unsupported types
    clr_log();
    wr(4'd2, 8'h54);
    rd(4'd0, v); chk("R13 block type fails", 32'(v), 32'h10);
    wr(4'd0, 8'h10);
    wr(4'd2, 8'h58);
    rd(4'd0, v); chk("R13 i2c block type fails", 32'(v), 32'h10);
    repeat (4) @(negedge clk);
    chk("R13 no bus activity", plog, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule